// File: doc/BRIEF.md
# SPI Register-Access Host with Ready Polling

This block is a SPI host that carries out register reads and writes on a serial target for a local requester. The requester hands over one command on a valid/ready port. A command holds a direction, a byte count from 1 to 64 and a 24-bit register address. The host lowers chip select and shifts out a four-byte header. It then watches the least significant bit of each byte it receives until the target signals that it is ready. After that it moves the payload straight away and raises chip select again.

Write payload bytes are pulled from a byte source, one pop per byte. Read payload bytes are pushed to the requester, one strobe per byte. If the target keeps signalling "not ready", a programmable limit on poll bytes ends the transaction. A one-cycle completion pulse reports whether the transaction finished normally or ran into the poll limit. The serial clock rate and the poll limit are set by static configuration inputs. The bus runs in SPI mode 0: SCLK idles low, both sides change data on the falling edge and sample it on the rising edge, and every byte is sent MSB first.

Top module: `spi_reg_host`

## Requirements
- R1: The header is four bytes. Byte 0 carries the direction in bit 7 (1 = read), a 0 in bit 6 and the byte count minus one in bits 5:0. Bytes 1 to 3 carry the address, most significant byte first.
- R2: The host ignores the LSB of received header bytes 0 to 2. If the LSB of received header byte 3 is 1, the payload begins on the very next byte.
- R3: While the last received LSB is 0, the host clocks further poll bytes, driving 0x00 on MOSI, and checks the LSB of each one. The first poll byte with LSB 1 is the last poll byte.
- R4: No more than `cfg_wait_max` poll bytes are clocked. If all of them return LSB 0, the transaction ends with a timeout. A limit of 0 means a timeout as soon as header byte 3 returns LSB 0. No payload byte moves on a timeout.
- R5: On a write, the host pops exactly count bytes from the source with `wr_pop`. It shifts them out in pop order as the bytes that immediately follow the ready byte.
- R6: On a read, the host drives 0x00 on MOSI during the payload. It delivers exactly count bytes on `rd_data`, in arrival order, each with a one-cycle `rd_valid` strobe.
- R7: `cs_n` stays low without a break from before the first header bit until after the last bit of the transaction. While `cs_n` is high, SCLK and MOSI are low.
- R8: Every SCLK half period lasts `cfg_div`+1 clock cycles. This includes the step from one byte to the next, so there is no pause between bytes.
- R9: After `cs_n` rises, `cmd_ready` stays low for exactly 4×(`cfg_div`+1) clock cycles, which is two SCLK periods.
- R10: `done` is a one-cycle pulse in the cycle that `cs_n` rises. `done_timeout` is 1 with it only for a transaction ended by the poll limit.
- R11: After reset, `cs_n` is 1, `cmd_ready` is 1 and SCLK, MOSI, `done`, `rd_valid` and `wr_pop` are 0. `cmd_ready` is 1 only while idle, and a command offered while busy is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | SCLK half period minus one, in clock cycles |
| cfg_wait_max | input | WAIT_W | Maximum number of poll bytes |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Host idle, command taken when valid is also high |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_len_m1 | input | LEN_W | Byte count minus one |
| cmd_addr | input | 8×HDR_ADDR_BYTES | Register address |
| wr_data | input | 8 | Head byte of the write source |
| wr_pop | output | 1 | Write byte consumed this cycle |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transaction end pulse |
| done_timeout | output | 1 | Transaction ended by the poll limit |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Host serial output |
| miso | input | 1 | Target serial input |

## Verification
`done` and the rise of `cs_n` come from the same clock edge. `rd_valid` follows the falling SCLK edge that completes a byte by one cycle. `cmd_ready` returns exactly 4×(`cfg_div`+1) cycles after `done`, and rising SCLK edges are 2×(`cfg_div`+1) cycles apart. The bench samples every output on the falling clock edge. It waits for the `done` event itself rather than counting a fixed number of cycles, because transaction length depends on the target's stall. It measures the two fixed intervals in exact cycles from the edges it has seen. A target model in the bench stalls for a chosen number of bytes and then checks the shifted stream byte by byte against the expected header, poll and payload layout.

// File: rtl/spi_reg_host_pkg.sv
package spi_reg_host_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} host_st_e;
    typedef enum logic [1:0] {PH_HDR, PH_POLL, PH_PAY} xfer_ph_e;
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             sclk_d, sclk_q;

    assign tick = en && (cnt_q == div);
    assign rise = tick && run && !sclk_q;
    assign fall = tick && run && sclk_q;
    assign sclk = sclk_q;

    always_comb begin
        cnt_d  = (!en || tick) ? '0 : cnt_q + DIV_W'(1);
        sclk_d = (!en || !run) ? 1'b0 : (tick ? !sclk_q : sclk_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            sclk_q <= sclk_d;
        end
    end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       rise,
    input  logic       fall,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    logic [7:0] tx_d, tx_q, rx_d, rx_q;
    logic [2:0] cnt_d, cnt_q;

    assign mosi      = tx_q[7];
    assign rx_byte   = rx_q;
    assign byte_done = fall && (cnt_q == 3'd7);

    always_comb begin
        tx_d  = tx_q;
        rx_d  = rx_q;
        cnt_d = cnt_q;
        if (rise) rx_d = {rx_q[6:0], miso};
        if (fall) begin
            tx_d  = {tx_q[6:0], 1'b0};
            cnt_d = cnt_q + 3'd1;
        end
        if (load) begin
            tx_d  = load_byte;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
        end else begin
            tx_q  <= tx_d;
            rx_q  <= rx_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_reg_host.sv
module spi_reg_host
    import spi_reg_host_pkg::*;
#(
    parameter int DIV_W          = 8,
    parameter int WAIT_W         = 16,
    parameter int LEN_W          = 6,
    parameter int HDR_ADDR_BYTES = 3,
    parameter int GAP_PERIODS    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DIV_W-1:0]            cfg_div,
    input  logic [WAIT_W-1:0]           cfg_wait_max,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic                        cmd_read,
    input  logic [LEN_W-1:0]            cmd_len_m1,
    input  logic [8*HDR_ADDR_BYTES-1:0] cmd_addr,
    input  logic [7:0]                  wr_data,
    output logic                        wr_pop,
    output logic                        rd_valid,
    output logic [7:0]                  rd_data,
    output logic                        done,
    output logic                        done_timeout,
    output logic                        sclk,
    output logic                        cs_n,
    output logic                        mosi,
    input  logic                        miso
);
    localparam int ADDR_W    = 8 * HDR_ADDR_BYTES;
    localparam int IDX_W     = $clog2(HDR_ADDR_BYTES + 1);
    localparam int GAP_TICKS = 2 * GAP_PERIODS;
    localparam int GAP_W     = $clog2(GAP_TICKS);

    typedef struct packed {
        host_st_e          st;
        xfer_ph_e          ph;
        logic              rd;
        logic [LEN_W-1:0]  len_m1;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic [WAIT_W-1:0] wcnt;
        logic [LEN_W-1:0]  pcnt;
        logic [GAP_W-1:0]  gcnt;
        logic              cs_n;
        logic              done;
        logic              tmo;
        logic              rdv;
        logic [7:0]        rdat;
    } host_regs_t;

    host_regs_t r_d, r_q;

    logic       tick, rise, fall, byte_done;
    logic       ld, pop, go_pay, go_end, go_tmo;
    logic [7:0] ld_byte, rx_byte;

    // Control byte: bit 7 direction, bit 6 zero, low bits count minus one.
    function automatic logic [7:0] ctrl_byte(input logic rd, input logic [LEN_W-1:0] lm1);
        logic [7:0] c;
        c            = '0;
        c[7]         = rd;
        c[LEN_W-1:0] = lm1;
        return c;
    endfunction

    // Address byte that follows header position idx, most significant first.
    function automatic logic [7:0] addr_byte(input logic [ADDR_W-1:0] a, input logic [IDX_W-1:0] idx);
        logic [ADDR_W-1:0] sh;
        sh = a << (8 * idx);
        return sh[ADDR_W-1 -: 8];
    endfunction

    spi_sclk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (r_q.st != ST_IDLE),
        .run  (r_q.st == ST_XFER),
        .div  (cfg_div),
        .tick (tick),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    spi_byte_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_byte(ld_byte),
        .rise     (rise),
        .fall     (fall),
        .miso     (miso),
        .mosi     (mosi),
        .rx_byte  (rx_byte),
        .byte_done(byte_done)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tmo  = 1'b0;
        r_d.rdv  = 1'b0;
        ld       = 1'b0;
        ld_byte  = '0;
        pop      = 1'b0;
        go_pay   = 1'b0;
        go_end   = 1'b0;
        go_tmo   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.st     = ST_XFER;
                    r_d.ph     = PH_HDR;
                    r_d.rd     = cmd_read;
                    r_d.len_m1 = cmd_len_m1;
                    r_d.addr   = cmd_addr;
                    r_d.idx    = '0;
                    r_d.cs_n   = 1'b0;
                    ld         = 1'b1;
                    ld_byte    = ctrl_byte(cmd_read, cmd_len_m1);
                end
            end
            ST_XFER: begin
                if (byte_done) begin
                    unique case (r_q.ph)
                        PH_HDR: begin
                            if (r_q.idx != IDX_W'(HDR_ADDR_BYTES)) begin
                                r_d.idx = r_q.idx + IDX_W'(1);
                                ld      = 1'b1;
                                ld_byte = addr_byte(r_q.addr, r_q.idx);
                            end else if (rx_byte[0]) begin
                                go_pay = 1'b1;
                            end else if (cfg_wait_max == '0) begin
                                go_tmo = 1'b1;
                            end else begin
                                r_d.ph   = PH_POLL;
                                r_d.wcnt = '0;
                                ld       = 1'b1;
                            end
                        end
                        PH_POLL: begin
                            if (rx_byte[0]) begin
                                go_pay = 1'b1;
                            end else if ((r_q.wcnt + WAIT_W'(1)) == cfg_wait_max) begin
                                go_tmo = 1'b1;
                            end else begin
                                r_d.wcnt = r_q.wcnt + WAIT_W'(1);
                                ld       = 1'b1;
                            end
                        end
                        PH_PAY: begin
                            if (r_q.rd) begin
                                r_d.rdv  = 1'b1;
                                r_d.rdat = rx_byte;
                            end
                            if (r_q.pcnt == r_q.len_m1) begin
                                go_end = 1'b1;
                            end else begin
                                r_d.pcnt = r_q.pcnt + LEN_W'(1);
                                ld       = 1'b1;
                                ld_byte  = r_q.rd ? 8'h00 : wr_data;
                                pop      = !r_q.rd;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.gcnt == GAP_W'(GAP_TICKS - 1)) r_d.st = ST_IDLE;
                    else r_d.gcnt = r_q.gcnt + GAP_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (go_pay) begin
            r_d.ph   = PH_PAY;
            r_d.pcnt = '0;
            ld       = 1'b1;
            ld_byte  = r_q.rd ? 8'h00 : wr_data;
            pop      = !r_q.rd;
        end
        if (go_end || go_tmo) begin
            r_d.st   = ST_GAP;
            r_d.gcnt = '0;
            r_d.cs_n = 1'b1;
            r_d.done = 1'b1;
            r_d.tmo  = go_tmo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready    = (r_q.st == ST_IDLE);
    assign cs_n         = r_q.cs_n;
    assign done         = r_q.done;
    assign done_timeout = r_q.tmo;
    assign rd_valid     = r_q.rdv;
    assign rd_data      = r_q.rdat;
    assign wr_pop       = pop;
endmodule

// File: rtl/spi_reg_host_chk.sv
module spi_reg_host_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic cmd_ready,
    input logic done,
    input logic done_timeout,
    input logic wr_pop,
    input logic rd_valid
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R7
    AST_MOSI_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !mosi); // R7
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready |-> cs_n); // R11
    AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(cs_n)); // R10
    AST_CS_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> done); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_TMO_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) done_timeout |-> done); // R10
    AST_POP_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n) wr_pop |-> !cs_n); // R5
    AST_STREAMS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({wr_pop, rd_valid})); // R6
endmodule

bind spi_reg_host spi_reg_host_chk u_chk (.*);

// File: tb/tb_spi_reg_host.sv
module tb_spi_reg_host;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_div = 8'd1;
    logic [15:0] cfg_wait_max = '0;
    logic        cmd_valid = 1'b0, cmd_read = 1'b0;
    logic [5:0]  cmd_len_m1 = '0;
    logic [23:0] cmd_addr = '0;
    logic [7:0]  wr_data, rd_data;
    logic        cmd_ready, wr_pop, rd_valid, done, done_timeout, sclk, cs_n, mosi;
    logic        miso = 1'b0;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    spi_reg_host dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_wait_max(cfg_wait_max),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
        .cmd_len_m1(cmd_len_m1), .cmd_addr(cmd_addr), .wr_data(wr_data), .wr_pop(wr_pop),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .done_timeout(done_timeout),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // Write source: the head byte is a function of the pop count.
    int wptr = 0;
    function automatic logic [7:0] wpat(int k);
        return 8'(k * 29 + 7);
    endfunction
    assign wr_data = wpat(wptr);
    always @(posedge clk) if (wr_pop) wptr <= wptr + 1;

    // Target model, SPI mode 0.
    int         t_byte = 0, t_bit = 0, stall_cfg = 0, csr_cnt = 0;
    logic [7:0] t_tx = '0, t_rx = '0, addr_lo = '0;
    logic [7:0] mcap [0:127];

    function automatic logic [7:0] rpat(int k, logic [7:0] a);
        return 8'(k * 13) ^ a ^ 8'h21;
    endfunction
    function automatic logic [7:0] resp(int n);
        if (n < 3) return 8'hA4 ^ 8'(n);
        if (n < 3 + stall_cfg) return 8'h5A;
        if (n == 3 + stall_cfg) return 8'hC3;
        return rpat(n - 4 - stall_cfg, addr_lo);
    endfunction

    always @(negedge cs_n) begin
        t_byte = 0; t_bit = 0; t_tx = resp(0); miso = t_tx[7];
    end
    always @(posedge cs_n) csr_cnt = csr_cnt + 1;
    always @(posedge sclk) if (!cs_n) begin
        t_rx = {t_rx[6:0], mosi};
        t_bit = t_bit + 1;
        if (t_bit == 8) begin
            if (t_byte < 128) mcap[t_byte] = t_rx;
            t_byte = t_byte + 1;
            t_bit = 0;
        end
    end
    always @(negedge sclk) if (!cs_n) begin
        if (t_bit == 0) t_tx = resp(t_byte);
        else t_tx = {t_tx[6:0], 1'b0};
        miso = t_tx[7];
    end

    // Monitors sampled on the falling clock edge.
    logic [7:0] rbuf [0:127];
    int rcnt = 0, cyc = 0, last_rise = 0, per_bad = 0;
    bit have_rise = 0;
    logic sclk_prev = 1'b0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rd_valid) begin
            if (rcnt < 128) rbuf[rcnt] = rd_data;
            rcnt = rcnt + 1;
        end
        if (sclk && !sclk_prev) begin
            if (have_rise && (cyc - last_rise) != 2 * (int'(cfg_div) + 1)) per_bad = per_bad + 1;
            last_rise = cyc;
            have_rise = 1;
        end
        sclk_prev = sclk;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        rd;
        logic [5:0]  lm1;
        logic [23:0] addr;
        logic [7:0]  stall;
        logic [7:0]  wmax;
        logic [7:0]  div;
        logic        tmo;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 6'd3,  24'hAABBCC, 8'd3, 8'd8, 8'd1, 1'b0},
        '{1'b1, 6'd3,  24'h123456, 8'd3, 8'd8, 8'd1, 1'b0},
        '{1'b0, 6'd0,  24'h00FF01, 8'd0, 8'd0, 8'd0, 1'b0},
        '{1'b1, 6'd63, 24'h8040C2, 8'd0, 8'd2, 8'd2, 1'b0},
        '{1'b1, 6'd1,  24'h7E7E7E, 8'd5, 8'd5, 8'd1, 1'b0},
        '{1'b0, 6'd2,  24'h010203, 8'd6, 8'd5, 8'd1, 1'b1},
        '{1'b1, 6'd0,  24'hFEDCBA, 8'd1, 8'd0, 8'd0, 1'b1},
        '{1'b0, 6'd63, 24'h5A5A00, 8'd2, 8'd3, 8'd3, 1'b0}
    };

    task automatic run_vec(input vec_t v, input bit hold_busy);
        int wstart, csr0, g, len, npoll, n, busy_bad;
        bit ok, tmo;
        while (!cmd_ready) @(negedge clk);
        cfg_div = v.div; cfg_wait_max = 16'(v.wmax);
        stall_cfg = int'(v.stall); addr_lo = v.addr[7:0];
        wstart = wptr; csr0 = csr_cnt; rcnt = 0; per_bad = 0; have_rise = 0;
        len = int'(v.lm1) + 1;
        cmd_read = v.rd; cmd_len_m1 = v.lm1; cmd_addr = v.addr; cmd_valid = 1'b1;
        @(negedge clk);
        busy_bad = 0;
        if (hold_busy) begin
            // R11: a second command offered while busy must not be taken
            cmd_read = !v.rd; cmd_addr = 24'h0BAD00; cmd_len_m1 = 6'd9;
            for (int i = 0; i < 20; i++) begin
                if (cmd_ready) busy_bad++;
                @(negedge clk);
            end
        end
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 100000) begin @(negedge clk); n++; end
        tmo = done_timeout;
        g = 0;
        while (!cmd_ready && g < 100000) begin @(negedge clk); g++; end
        npoll = v.tmo ? int'(v.wmax) : int'(v.stall);
        if (hold_busy) chk(busy_bad == 0, "R11 busy ready", busy_bad, 0);
        chk(tmo == v.tmo, "R10 timeout flag", tmo, v.tmo);
        chk(t_byte == 4 + npoll + (v.tmo ? 0 : len), "R2 byte count", t_byte,
            4 + npoll + (v.tmo ? 0 : len));
        chk({mcap[0], mcap[1], mcap[2], mcap[3]} == {v.rd, 1'b0, v.lm1, v.addr}, "R1 header",
            {mcap[0], mcap[1], mcap[2], mcap[3]}, {v.rd, 1'b0, v.lm1, v.addr});
        ok = 1;
        for (int i = 4; i < 4 + npoll; i++) if (mcap[i] != 8'h00) ok = 0;
        chk(ok, "R3 poll bytes zero on MOSI", ok, 1);
        if (v.tmo) begin
            chk(wptr == wstart && rcnt == 0, "R4 no payload on timeout", wptr - wstart + rcnt, 0);
        end else if (!v.rd) begin
            ok = (wptr - wstart == len);
            for (int k = 0; k < len; k++) if (mcap[4 + npoll + k] != wpat(wstart + k)) ok = 0;
            chk(ok, "R5 write payload", wptr - wstart, len);
        end else begin
            ok = (rcnt == len);
            for (int k = 0; k < len; k++) begin
                if (rbuf[k] != rpat(k, v.addr[7:0])) ok = 0;
                if (mcap[4 + npoll + k] != 8'h00) ok = 0;
            end
            chk(ok, "R6 read payload", rcnt, len);
        end
        chk(csr_cnt - csr0 == 1, "R7 single chip-select window", csr_cnt - csr0, 1);
        chk(per_bad == 0, "R8 sclk period", per_bad, 0);
        chk(g == 4 * (int'(v.div) + 1), "R9 deassert gap", g, 4 * (int'(v.div) + 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(cs_n && !sclk && !mosi && cmd_ready && !done && !rd_valid && !wr_pop, "R11 reset state",
            {cs_n, sclk, mosi, cmd_ready, done, rd_valid, wr_pop}, 7'b1001000);
        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
        // R11 command held while busy, then R4 timeout followed by a normal run
        run_vec('{1'b1, 6'd3, 24'hC0FFEE, 8'd2, 8'd4, 8'd1, 1'b0}, 1'b1);
        run_vec('{1'b0, 6'd1, 24'h000001, 8'd3, 8'd2, 8'd0, 1'b1}, 1'b0);
        run_vec('{1'b0, 6'd1, 24'h000002, 8'd2, 8'd2, 8'd0, 1'b0}, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule